// File: doc/BRIEF.md
# Character LCD Parallel Bus Master

This block sits on the host side of a dot-matrix character LCD controller and runs its asynchronous parallel bus: the register-select line, the read/not-write line, the enable strobe and the eight data lines. The host presents a request with a register-select bit, a direction flag and a byte. The block turns it into one or two enable strobes whose setup, pulse-width, hold, start-to-start spacing and read-sampling windows all meet fixed nanosecond minimums. It then pulses a completion flag, with the read byte alongside it.

Every window is a parameter in nanoseconds. It is converted at elaboration into a clock-cycle count, rounding up, against the clock period parameter. The bus width is chosen at elaboration: either eight data lines, or four lines (DB7-DB4) carrying two nibble strobes per byte. The outgoing data drivers are enabled only during the strobe phases of a write. The enable input of the data bus is kept separate from the data lines, so the pad ring can build the tristate buffer.

Top module: `lcd_bus_master`

## Requirements
- R1: A request (`req_valid` high while `req_ready` is high) is accepted at that clock edge, and `req_ready` is low in the next cycle. `req_valid` pulses while `req_ready` is low have no effect on the bus or on the data written.
- R2: Rising edges of `lcd_e` are at least ceil(1000/T) clock cycles apart, T being `CLK_PERIOD_NS`. This holds within a byte and across requests.
- R3: `lcd_e` stays high for max(ceil(450/T), ceil(320/T), ceil(195/T)) clock cycles in every strobe.
- R4: `lcd_rs` and `lcd_rnw` do not change during the ceil(140/T) cycles before `lcd_e` rises, while `lcd_e` is high, or during the ceil(10/T) cycles after it falls.
- R5: On a write, `lcd_db_out` is stable and `lcd_db_oe` is high from the start of the setup phase, so at least 195 ns before `lcd_e` falls, until ceil(10/T) cycles after it falls. `lcd_db_oe` is low on reads and while idle.
- R6: Read data is sampled on the last clock of the `lcd_e` high phase, at least 320 ns after the rising edge, and is presented on `rd_data` while `done` is high.
- R7: With `NIBBLE_MODE` = 0, each request makes exactly one strobe, and the whole byte travels on DB7-DB0 with bit i on line i.
- R8: With `NIBBLE_MODE` = 1, each request makes exactly two strobes on DB7-DB4: bits 7:4 of the byte first, then bits 3:0. DB3-DB0 are driven low. A read assembles the two nibbles the same way.
- R9: `done` is high for exactly one cycle per request. When a request is accepted after the bus has been quiet for at least ceil(1000/T) cycles, `done` rises 1+S+H+D cycles after the accepting edge in 8-bit mode, and C+1+S+H+D cycles after it in 4-bit mode. Here S = ceil(140/T), H is the high width of R3, D = ceil(10/T) and C = ceil(1000/T).
- R10: During reset, `lcd_e`, `lcd_db_oe` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe from the host |
| req_rs | input | 1 | Register-select value for the request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_data | input | 8 | Byte to write |
| req_ready | output | 1 | High while idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read, valid with `done` |
| lcd_rs | output | 1 | Register-select line to the LCD |
| lcd_rnw | output | 1 | Read/not-write line to the LCD |
| lcd_e | output | 1 | Enable strobe to the LCD |
| lcd_db_out | output | 8 | Data driven toward the LCD |
| lcd_db_oe | output | 1 | Output enable for the data lines |
| lcd_db_in | input | 8 | Data lines as seen from the LCD |

## Verification
At the default 8 ns period, `done` is due 78 cycles after the accepting edge in 8-bit mode and 203 cycles after it in 4-bit mode. This assumes the bus has been quiet for 125 cycles. The bench computes these counts from the nanosecond limits and counts falling clock edges from acceptance, so an exact-latency check is made only after a quiet gap of 150 cycles; back-to-back requests are held only to a lower bound. Bus timing is measured in nanoseconds by an LCD model that changes its read data to a wrong value at each rising edge of the strobe and drives the right value only 320 ns later. A sample taken too early therefore returns the wrong byte. Written bytes, strobe counts and violation counters are compared one falling edge after `done`, when all strobes of the request have ended.

// File: rtl/lcd_bus_pkg.sv
`timescale 1ns/1ps
// Package: shared phase type and elaboration-time helpers for the LCD bus master.
// Assumes all arguments are positive nanosecond or cycle counts.
package lcd_bus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_GAP   = 3'd1,
        PH_SETUP = 3'd2,
        PH_HIGH  = 3'd3,
        PH_HOLD  = 3'd4
    } lcd_phase_e;

    // Convert a nanosecond minimum into clock cycles, rounding up, never below one.
    function automatic int unsigned lcd_ns2clk(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned lcd_max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_bus_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter that saturates at zero.
// A load of N-1 makes zero rise after N cycles. Assumes load values fit in W bits.
module lcd_bus_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count down toward zero, or restart from the load value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_bus_seq.sv
`timescale 1ns/1ps
// Module: bus-cycle sequencer. Walks GAP -> SETUP -> HIGH -> HOLD for each strobe,
// repeating for the second nibble in 4-bit mode. A phase timer sets phase lengths.
// A spacing timer, restarted at each strobe rise, keeps rises N_AS+N_SPACE cycles apart.
// Bus controls are registered from the next phase so they change only at clock edges.
module lcd_bus_seq
    import lcd_bus_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned N_AS    = 18,
    parameter int unsigned N_HI    = 57,
    parameter int unsigned N_HD    = 2,
    parameter int unsigned N_SPACE = 107,
    parameter int unsigned BEATS   = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         ph_zero,
    input  logic         sp_zero,
    output logic         ph_load,
    output logic [W-1:0] ph_val,
    output logic         sp_load,
    output logic [W-1:0] sp_val,
    output logic         req_ready,
    output logic         accept,
    output logic         beat,
    output logic         sample,
    output logic         bus_on_next,
    output logic         e_q,
    output logic         done_q
);

    localparam logic [W-1:0] V_AS    = W'(N_AS - 1);
    localparam logic [W-1:0] V_HI    = W'(N_HI - 1);
    localparam logic [W-1:0] V_HD    = W'(N_HD - 1);
    localparam logic [W-1:0] V_SPACE = W'(N_SPACE - 1);
    localparam logic         LAST    = (BEATS == 2);

    lcd_phase_e ph_q, ph_d;
    logic       beat_d;
    logic       finish;

    assign sp_val = V_SPACE;

    // Next-phase decision and timer loads.
    always_comb begin
        ph_d    = ph_q;
        beat_d  = beat;
        ph_load = 1'b0;
        ph_val  = '0;
        sp_load = 1'b0;
        accept  = 1'b0;
        finish  = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    ph_d   = PH_GAP;
                    beat_d = 1'b0;
                end
            end
            PH_GAP: begin
                if (sp_zero) begin
                    ph_d    = PH_SETUP;
                    ph_load = 1'b1;
                    ph_val  = V_AS;
                end
            end
            PH_SETUP: begin
                if (ph_zero) begin
                    ph_d    = PH_HIGH;
                    ph_load = 1'b1;
                    ph_val  = V_HI;
                    sp_load = 1'b1;
                end
            end
            PH_HIGH: begin
                if (ph_zero) begin
                    ph_d    = PH_HOLD;
                    ph_load = 1'b1;
                    ph_val  = V_HD;
                end
            end
            PH_HOLD: begin
                if (ph_zero) begin
                    if (beat == LAST) begin
                        ph_d   = PH_IDLE;
                        finish = 1'b1;
                    end else begin
                        ph_d   = PH_GAP;
                        beat_d = 1'b1;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase and beat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_IDLE;
            beat <= 1'b0;
        end else begin
            ph_q <= ph_d;
            beat <= beat_d;
        end
    end

    assign bus_on_next = (ph_d == PH_SETUP) || (ph_d == PH_HIGH) || (ph_d == PH_HOLD);

    // Registered strobe and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            e_q    <= (ph_d == PH_HIGH);
            done_q <= finish;
        end
    end

    assign req_ready = (ph_q == PH_IDLE);
    assign sample    = (ph_q == PH_HIGH) && ph_zero;

endmodule

// File: rtl/lcd_bus_datapath.sv
`timescale 1ns/1ps
// Module: request latch, data-line steering and read capture.
// 8-bit mode drives the byte on all lines. 4-bit mode drives the high nibble on
// DB7-DB4 during beat 0 and the low nibble during beat 1, with DB3-DB0 low.
// Assumes accept arrives only when the sequencer is idle.
module lcd_bus_datapath #(
    parameter bit NIBBLE_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       req_rs,
    input  logic       req_rnw,
    input  logic [7:0] req_data,
    input  logic       beat,
    input  logic       sample,
    input  logic       bus_on_next,
    input  logic [7:0] db_in,
    output logic       rs,
    output logic       rnw,
    output logic [7:0] db_out,
    output logic       db_oe,
    output logic [7:0] rd_data
);

    logic [7:0] byte_q;

    // Latch register select, direction and byte when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs     <= 1'b0;
            rnw    <= 1'b1;
            byte_q <= '0;
        end else if (accept) begin
            rs     <= req_rs;
            rnw    <= req_rnw;
            byte_q <= req_data;
        end
    end

    // Drive the data lines only during the strobe phases of a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            db_oe <= 1'b0;
        else
            db_oe <= bus_on_next && !rnw;
    end

    generate
        if (NIBBLE_MODE) begin : g_nib
            logic unused_lo;
            assign unused_lo = ^db_in[3:0];

            // Pick the nibble for the current beat.
            always_comb db_out = {(beat ? byte_q[3:0] : byte_q[7:4]), 4'h0};

            // Assemble the read byte one nibble per strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rd_data <= '0;
                else if (sample) begin
                    if (beat)
                        rd_data[3:0] <= db_in[7:4];
                    else
                        rd_data[7:4] <= db_in[7:4];
                end
            end
        end else begin : g_byte
            logic unused_beat;
            assign unused_beat = beat;

            // Whole byte on all eight lines.
            always_comb db_out = byte_q;

            // Capture the full byte at the end of the strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rd_data <= '0;
                else if (sample)
                    rd_data <= db_in;
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_bus_master.sv
`timescale 1ns/1ps
// Module: host-side master for a character LCD parallel bus.
// Converts nanosecond bus minimums into cycle counts at elaboration and sequences
// one strobe per byte (8-bit mode) or two per byte (4-bit mode).
// Assumes a free-running clk of period CLK_PERIOD_NS and an external tristate pad.
module lcd_bus_master
    import lcd_bus_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter bit          NIBBLE_MODE   = 1'b0,
    parameter int unsigned T_CYC_NS      = 1000,
    parameter int unsigned T_PW_NS       = 450,
    parameter int unsigned T_AS_NS       = 140,
    parameter int unsigned T_AH_NS       = 10,
    parameter int unsigned T_DSW_NS      = 195,
    parameter int unsigned T_DH_NS       = 10,
    parameter int unsigned T_DDR_NS      = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_rs,
    input  logic       req_rnw,
    input  logic [7:0] req_data,
    output logic       req_ready,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       lcd_rs,
    output logic       lcd_rnw,
    output logic       lcd_e,
    output logic [7:0] lcd_db_out,
    output logic       lcd_db_oe,
    input  logic [7:0] lcd_db_in
);

    localparam int unsigned N_AS    = lcd_ns2clk(T_AS_NS, CLK_PERIOD_NS);
    localparam int unsigned N_PW    = lcd_ns2clk(T_PW_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DSW   = lcd_ns2clk(T_DSW_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DDR   = lcd_ns2clk(T_DDR_NS, CLK_PERIOD_NS);
    localparam int unsigned N_HI    = lcd_max2(lcd_max2(N_PW, N_DDR), N_DSW);
    localparam int unsigned N_HD    = lcd_max2(lcd_ns2clk(T_AH_NS, CLK_PERIOD_NS),
                                               lcd_ns2clk(T_DH_NS, CLK_PERIOD_NS));
    localparam int unsigned N_CYC   = lcd_ns2clk(T_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_SPACE = (N_CYC > N_AS + 1) ? (N_CYC - N_AS) : 1;
    localparam int unsigned BEATS   = NIBBLE_MODE ? 2 : 1;
    localparam int unsigned TW      = $clog2(lcd_max2(lcd_max2(N_HI, N_SPACE),
                                                      lcd_max2(N_AS, N_HD)) + 1);

    logic          ph_load, sp_load, ph_zero, sp_zero;
    logic [TW-1:0] ph_val, sp_val;
    logic          accept, beat, sample, bus_on_next;

    lcd_bus_timer #(.W(TW)) u_phase_tmr (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    lcd_bus_timer #(.W(TW)) u_space_tmr (
        .clk(clk), .rst_n(rst_n), .load(sp_load), .load_val(sp_val), .zero(sp_zero)
    );

    lcd_bus_seq #(
        .W(TW), .N_AS(N_AS), .N_HI(N_HI), .N_HD(N_HD), .N_SPACE(N_SPACE), .BEATS(BEATS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .ph_zero(ph_zero), .sp_zero(sp_zero),
        .ph_load(ph_load), .ph_val(ph_val), .sp_load(sp_load), .sp_val(sp_val),
        .req_ready(req_ready), .accept(accept), .beat(beat), .sample(sample),
        .bus_on_next(bus_on_next), .e_q(lcd_e), .done_q(done)
    );

    lcd_bus_datapath #(.NIBBLE_MODE(NIBBLE_MODE)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .req_rs(req_rs), .req_rnw(req_rnw), .req_data(req_data),
        .beat(beat), .sample(sample), .bus_on_next(bus_on_next), .db_in(lcd_db_in),
        .rs(lcd_rs), .rnw(lcd_rnw), .db_out(lcd_db_out), .db_oe(lcd_db_oe),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/lcd_bus_master_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound to lcd_bus_master. Measures strobe width and
// rise-to-rise spacing with its own saturating counters.
module lcd_bus_master_chk
    import lcd_bus_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned T_CYC_NS      = 1000,
    parameter int unsigned T_PW_NS       = 450
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic lcd_e,
    input logic lcd_rs,
    input logic lcd_rnw,
    input logic lcd_db_oe
);

    localparam int unsigned C_PW  = lcd_ns2clk(T_PW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_CYC = lcd_ns2clk(T_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned CW    = $clog2(lcd_max2(C_PW, C_CYC) + 1) + 1;
    localparam logic [CW-1:0] CMAX = CW'(lcd_max2(C_PW, C_CYC));

    logic          e_prev;
    logic [CW-1:0] hi_cnt, gap_cnt;

    // Track strobe history: previous level, high run length, cycles since last rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_prev  <= 1'b0;
            hi_cnt  <= '0;
            gap_cnt <= CMAX;
        end else begin
            e_prev <= lcd_e;
            if (!lcd_e)
                hi_cnt <= '0;
            else if (hi_cnt != CMAX)
                hi_cnt <= hi_cnt + 1'b1;
            if (lcd_e && !e_prev)
                gap_cnt <= CW'(1);
            else if (gap_cnt != CMAX)
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    // R1
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_db_oe |-> !lcd_rnw);

    // R4
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && e_prev) |-> ($stable(lcd_rs) && $stable(lcd_rnw)));

    // R3
    e_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_e && e_prev) |-> (hi_cnt >= CW'(C_PW)));

    // R2
    e_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_e && !e_prev) |-> (gap_cnt >= CW'(C_CYC)));

endmodule

bind lcd_bus_master lcd_bus_master_chk #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_CYC_NS(T_CYC_NS), .T_PW_NS(T_PW_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rnw(lcd_rnw),
    .lcd_db_oe(lcd_db_oe)
);

// File: tb/lcd_panel_model.sv
`timescale 1ns/1ps
// Bench model of the LCD side: measures bus timing in nanoseconds, counts
// violations by kind, records written bytes and serves read data late.
module lcd_panel_model #(
    parameter bit NIB = 1'b0
) (
    input  logic       rs,
    input  logic       rnw,
    input  logic       e,
    input  logic       db_oe,
    input  logic [7:0] db_out,
    input  logic [7:0] rd_byte,
    output logic [7:0] db_in,
    output int         v_cyc,
    output int         v_pw,
    output int         v_addr,
    output int         v_data,
    output int         e_cnt,
    output logic [7:0] wr_byte,
    output logic       wr_rs
);

    realtime t_rise = 0, t_fall = 0, t_addr = 0, t_data = 0;
    bit      had_rise = 0, had_fall = 0, last_wr = 0;
    int      va_chg = 0, va_su = 0, vd_chg = 0, vd_fall = 0;

    assign v_addr = va_chg + va_su;
    assign v_data = vd_chg + vd_fall;

    function automatic logic [7:0] beat_val(input int n);
        if (!NIB) return rd_byte;
        return n[0] ? {rd_byte[3:0], 4'h0} : {rd_byte[7:4], 4'h0};
    endfunction

    // Address lines must not move while E is high or within the hold after it falls.
    always @(rs or rnw) begin
        if (e === 1'b1) va_chg++;
        else if (had_fall && ($realtime - t_fall) < 10.0) va_chg++;
        t_addr = $realtime;
    end

    // Write data must not move while E is high or within the hold after it falls.
    always @(db_out or db_oe) begin
        if (e === 1'b1 && rnw === 1'b0) vd_chg++;
        else if (had_fall && last_wr && ($realtime - t_fall) < 10.0) vd_chg++;
        t_data = $realtime;
    end

    // One strobe at a time: setup, spacing, width, read data timing, write capture.
    initial begin
        v_cyc = 0; v_pw = 0; e_cnt = 0; wr_byte = 8'h00; wr_rs = 1'b0; db_in = 8'h00;
        forever begin
            @(posedge e);
            if (($realtime - t_addr) < 140.0) va_su++;
            if (had_rise && ($realtime - t_rise) < 1000.0) v_cyc++;
            t_rise = $realtime;
            had_rise = 1;
            if (rnw === 1'b1) begin
                db_in = ~beat_val(e_cnt);
                while (e === 1'b1 && ($realtime - t_rise) < 320.0) #1;
                if (e === 1'b1) db_in = beat_val(e_cnt);
            end
            if (e === 1'b1) @(negedge e);
            if (($realtime - t_rise) < 450.0) v_pw++;
            t_fall = $realtime;
            had_fall = 1;
            last_wr = (rnw === 1'b0);
            if (last_wr) begin
                if (db_oe !== 1'b1 || ($realtime - t_data) < 195.0) vd_fall++;
                if (NIB) begin
                    if (db_out[3:0] != 4'h0) vd_fall++;
                    if (e_cnt[0]) wr_byte[3:0] = db_out[7:4];
                    else          wr_byte[7:4] = db_out[7:4];
                end else begin
                    wr_byte = db_out;
                end
                wr_rs = rs;
            end
            e_cnt++;
            if (!last_wr) begin
                #20;
                db_in = 8'h96;
            end
        end
    end

endmodule

// File: tb/lcd_bus_master_bench.sv
`timescale 1ns/1ps
// Bench: index 0 is the 8-bit instance, index 1 the 4-bit instance.
module lcd_bus_master_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n;

    logic       req_valid [2], req_rs [2], req_rnw [2];
    logic [7:0] req_data [2];
    logic       req_ready [2], done [2];
    logic [7:0] rd_data [2];
    logic       lcd_rs [2], lcd_rnw [2], lcd_e [2], lcd_db_oe [2];
    logic [7:0] lcd_db_out [2], lcd_db_in [2], rd_byte [2];
    int         v_cyc [2], v_pw [2], v_addr [2], v_data [2], e_cnt [2];
    logic [7:0] wr_byte [2];
    logic       wr_rs [2];

    int checks = 0, fails = 0;

    lcd_bus_master #(.CLK_PERIOD_NS(8), .NIBBLE_MODE(1'b0)) u_lcd_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_rs(req_rs[0]),
        .req_rnw(req_rnw[0]), .req_data(req_data[0]), .req_ready(req_ready[0]),
        .done(done[0]), .rd_data(rd_data[0]), .lcd_rs(lcd_rs[0]), .lcd_rnw(lcd_rnw[0]),
        .lcd_e(lcd_e[0]), .lcd_db_out(lcd_db_out[0]), .lcd_db_oe(lcd_db_oe[0]),
        .lcd_db_in(lcd_db_in[0])
    );

    lcd_bus_master #(.CLK_PERIOD_NS(8), .NIBBLE_MODE(1'b1)) u_lcd_bus_master_nib (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_rs(req_rs[1]),
        .req_rnw(req_rnw[1]), .req_data(req_data[1]), .req_ready(req_ready[1]),
        .done(done[1]), .rd_data(rd_data[1]), .lcd_rs(lcd_rs[1]), .lcd_rnw(lcd_rnw[1]),
        .lcd_e(lcd_e[1]), .lcd_db_out(lcd_db_out[1]), .lcd_db_oe(lcd_db_oe[1]),
        .lcd_db_in(lcd_db_in[1])
    );

    lcd_panel_model #(.NIB(1'b0)) u_panel0 (
        .rs(lcd_rs[0]), .rnw(lcd_rnw[0]), .e(lcd_e[0]), .db_oe(lcd_db_oe[0]),
        .db_out(lcd_db_out[0]), .rd_byte(rd_byte[0]), .db_in(lcd_db_in[0]),
        .v_cyc(v_cyc[0]), .v_pw(v_pw[0]), .v_addr(v_addr[0]), .v_data(v_data[0]),
        .e_cnt(e_cnt[0]), .wr_byte(wr_byte[0]), .wr_rs(wr_rs[0])
    );

    lcd_panel_model #(.NIB(1'b1)) u_panel1 (
        .rs(lcd_rs[1]), .rnw(lcd_rnw[1]), .e(lcd_e[1]), .db_oe(lcd_db_oe[1]),
        .db_out(lcd_db_out[1]), .rd_byte(rd_byte[1]), .db_in(lcd_db_in[1]),
        .v_cyc(v_cyc[1]), .v_pw(v_pw[1]), .v_addr(v_addr[1]), .v_data(v_data[1]),
        .e_cnt(e_cnt[1]), .wr_byte(wr_byte[1]), .wr_rs(wr_rs[1])
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int ns);
        return (ns + 7) / 8;
    endfunction

    // Cycle of the done pulse after the accepting edge, bus quiet beforehand (R9).
    function automatic int exp_done(input int m);
        int s, h, d, c;
        s = cdiv(140);
        h = cdiv(450);
        if (cdiv(320) > h) h = cdiv(320);
        if (cdiv(195) > h) h = cdiv(195);
        d = cdiv(10);
        c = cdiv(1000);
        return (m == 1) ? (c + 1 + s + h + d) : (1 + s + h + d);
    endfunction

    task automatic run_txn(input int m, input logic rs, input logic rnw,
                           input logic [7:0] d, input logic [7:0] rb,
                           input bit exact, input bit poke);
        int lat, b_cyc, b_pw, b_addr, b_data, b_e;
        string tag;
        tag = (m == 1) ? "R8" : "R7";
        @(negedge clk);
        while (!req_ready[m]) @(negedge clk);
        rd_byte[m] = rb;
        b_cyc = v_cyc[m]; b_pw = v_pw[m]; b_addr = v_addr[m]; b_data = v_data[m];
        b_e = e_cnt[m];
        req_valid[m] = 1'b1; req_rs[m] = rs; req_rnw[m] = rnw; req_data[m] = d;
        @(posedge clk);
        @(negedge clk);
        req_valid[m] = 1'b0;
        check(req_ready[m] == 1'b0, "R1 ready low after accept", int'(req_ready[m]), 0);
        lat = 1;
        while (!done[m] && lat < 4000) begin
            if (poke && lat == 5) begin
                req_valid[m] = 1'b1; req_data[m] = ~d; req_rs[m] = ~rs;
            end else if (poke && lat == 6) begin
                req_valid[m] = 1'b0; req_data[m] = d; req_rs[m] = rs;
            end
            @(negedge clk);
            lat++;
        end
        if (exact)
            check(lat == exp_done(m) + 1, "R9 done latency", lat - 1, exp_done(m));
        else
            check(lat >= exp_done(m) + 1, "R9 done latency bound", lat - 1, exp_done(m));
        check(lcd_db_oe[m] == 1'b0, "R5 oe low at completion", int'(lcd_db_oe[m]), 0);
        if (rnw)
            check(rd_data[m] == rb, {"R6 ", tag, " read byte"}, int'(rd_data[m]), int'(rb));
        else begin
            check(wr_byte[m] == d, {"R5 ", tag, " written byte"}, int'(wr_byte[m]), int'(d));
            check(wr_rs[m] == rs, "R4 register select at strobe", int'(wr_rs[m]), int'(rs));
        end
        @(negedge clk);
        check(done[m] == 1'b0, "R9 done one cycle", int'(done[m]), 0);
        check(e_cnt[m] - b_e == m + 1, {tag, poke ? " R1" : "", " strobes per byte"},
              e_cnt[m] - b_e, m + 1);
        check(v_cyc[m] == b_cyc, "R2 strobe spacing", v_cyc[m] - b_cyc, 0);
        check(v_pw[m] == b_pw, "R3 strobe width", v_pw[m] - b_pw, 0);
        check(v_addr[m] == b_addr, "R4 address setup/hold", v_addr[m] - b_addr, 0);
        check(v_data[m] == b_data, {"R5 ", tag, " data setup/hold/lines"},
              v_data[m] - b_data, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        rst_n = 1'b0;
        for (int m = 0; m < 2; m++) begin
            req_valid[m] = 1'b0; req_rs[m] = 1'b0; req_rnw[m] = 1'b0;
            req_data[m] = 8'h00; rd_byte[m] = 8'h00;
        end
        repeat (6) @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            check(lcd_e[m] == 1'b0, "R10 e low in reset", int'(lcd_e[m]), 0);
            check(lcd_db_oe[m] == 1'b0, "R10 oe low in reset", int'(lcd_db_oe[m]), 0);
            check(done[m] == 1'b0, "R10 done low in reset", int'(done[m]), 0);
            check(req_ready[m] == 1'b1, "R10 ready high in reset", int'(req_ready[m]), 1);
        end
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            repeat (150) @(posedge clk);
            run_txn(m, 1'b1, 1'b0, 8'h3C, 8'h00, 1'b1, 1'b0);
            repeat (150) @(posedge clk);
            run_txn(m, 1'b0, 1'b1, 8'h00, 8'hA7, 1'b1, 1'b0);
            repeat (150) @(posedge clk);
            run_txn(m, 1'b0, 1'b0, 8'h5A, 8'h00, 1'b1, 1'b1);
            run_txn(m, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0, 1'b0);
            run_txn(m, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
            run_txn(m, 1'b1, 1'b1, 8'h00, 8'h0F, 1'b0, 1'b0);
            for (int i = 0; i < 24; i++) begin
                logic [7:0] d, rb;
                logic rs, rnw;
                d = 8'($urandom); rb = 8'($urandom);
                rs = 1'($urandom); rnw = 1'($urandom);
                repeat ($urandom_range(0, 3)) @(posedge clk);
                run_txn(m, rs, rnw, d, rb, 1'b0, (i % 7) == 3);
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule